// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the protocol layer on the target side of an SMBus device that holds a bank of 8-bit registers. A bit-level front end, outside this block, turns the bus wires into byte events: a start, a stop, an address byte, a received data byte, a request for the next byte to transmit, and the master's acknowledge of a transmitted byte. The responder answers each address byte, write byte and transmit request with an ACK or NACK decision and, for transmit requests, the byte to drive.

The first byte written after the address is the command byte. Its low seven bits choose the register, and its top bit chooses block framing. In plain mode, written bytes land in consecutive registers and reads stream consecutive registers. Word transfers are simply two such bytes, low byte first. In block mode, a write carries a count byte before its data, and a read sends a count byte before the payload. A repeated start that is followed by a read address keeps the command. The last command also survives a stop, so a later bare read (Receive Byte) returns data from that register.

Events arrive on a valid/ready stream. The responder can take an event whenever `ev_ready` is high. After it accepts an address, write-data or transmit-request event, it presents its answer on `rsp_*` for exactly one cycle, and `ev_ready` is low during that cycle. The response has no ready input: the front end must capture it in that one cycle. Start, stop and master-acknowledge events produce no response and do not drop `ev_ready`.

Top module: `smbus_target_resp`

## Requirements
- R1: The address byte is {addr[6:0], rw} with rw=1 for a read. It is ACKed only when it follows a start and addr equals TGT_ADDR (default 0x3A). A foreign address is NACKed, and every write byte after it is NACKed and discarded until the next start.
- R2: In a write transaction, the first byte after the address is the command byte. It is always ACKed. Its bits [6:0] set the register pointer. If bit 7 is 0, the following bytes are stored starting at that register.
- R3: Consecutive data bytes go to consecutive registers and wrap from 0x7F to 0x00. A word write therefore stores the low byte at the command register and the high byte at the next one.
- R4: A repeated start followed by a read address keeps the command. Transmit requests then return the command register and the registers after it, one per master ACK, so a word read returns the low byte first.
- R5: A read with no command byte in its own transaction (Receive Byte) returns the register chosen by the most recent command, even across stops. It never sends a count byte, even when that command had bit 7 set.
- R6: A command with bit 7 set starts a block write. The next byte is a count. A count from 1 to 32 is ACKed, and exactly that many data bytes are then stored and ACKed. Any further byte is NACKed and discarded.
- R7: A block count of 0, or of more than 32, is NACKed. All following write bytes are NACKed and discarded.
- R8: After a block command, a repeated start and a read address, the first transmitted byte is the count RD_BLK_LEN (default 4). Then that many register bytes follow, starting at the command register. A request after them gets ack=0 and byte 0xFF.
- R9: A master NACK (ev_kind 5 with ev_byte[0]=0) ends the read. Later transmit requests get ack=0 and byte 0xFF.
- R10: A stop returns the responder to idle, so a write byte that follows without a start is NACKed and discarded. The register pointer is kept.
- R11: The ev_kind codes are 0 start, 1 stop, 2 address, 3 write byte, 4 transmit request, and 5 master acknowledge (ev_byte[0]=1 means ACK). Kinds 2, 3 and 4 are answered with rsp_valid high for one cycle, the cycle after acceptance, and ev_ready is low in that cycle. Kinds 0, 1 and 5 get no response.
- R12: After reset, rsp_valid is 0, ev_ready is 1, the pointer is 0 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Bus event is valid |
| ev_ready | output | 1 | Responder can accept an event |
| ev_kind | input | 3 | Event code |
| ev_byte | input | 8 | Address, data, or acknowledge bit (bit 0) |
| rsp_valid | output | 1 | Response is present this cycle |
| rsp_ack | output | 1 | 1: ACK, or a valid transmit byte; 0: NACK, or no data |
| rsp_byte | output | 8 | Byte to transmit (0xFF when nothing is sent) |

## Verification
Writes are tried as single bytes, as words, and as runs that cross the 0x7F boundary, so that storage order and pointer wrap can be told apart. Reads are tried after a repeated start, as bare Receive Byte reads after stops, and after block commands. This separates a command kept within a transaction from one kept across transactions, and shows whether a count byte is inserted only where it belongs. Block counts of 0, 3, 32 and 33 exercise both edges of the legal range and the handling of excess bytes. A foreign address, a stop-then-write sequence and a master NACK check that discarded traffic changes neither the registers nor the pointer.

// File: rtl/smbus_resp_pkg.sv
package smbus_resp_pkg;
  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_STOP  = 3'd1,
    EV_ADDR  = 3'd2,
    EV_WDATA = 3'd3,
    EV_TXREQ = 3'd4,
    EV_MACK  = 3'd5
  } ev_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_CNT,
    S_WDAT,
    S_DROP,
    S_RD,
    S_RDONE
  } proto_st_e;

  typedef struct packed {
    logic       ack;
    logic [7:0] data;
  } rsp_t;
endpackage

// File: rtl/smbus_regbank.sv
module smbus_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << AW;

  logic [NREG*DW-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we && waddr == AW'(i)) q <= wdata;
    end
    assign flat[i*DW +: DW] = q;
  end

  assign rdata = flat[raddr*DW +: DW];
endmodule

// File: rtl/smbus_proto.sv
module smbus_proto
  import smbus_resp_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR   = 7'h3A,
  parameter int         AW         = 7,
  parameter int         MAX_BLK    = 32,
  parameter int         RD_BLK_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [2:0]    kind,
  input  logic [7:0]    ev_byte,
  input  logic [7:0]    rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] raddr,
  output logic          need_rsp,
  output rsp_t          rsp_d
);
  localparam int CW = $clog2(MAX_BLK + 1);

  proto_st_e     st, st_n;
  logic [AW-1:0] cmd_ptr, cmd_ptr_n;
  logic [AW-1:0] wptr, wptr_n;
  logic          blk_sel, blk_sel_n;
  logic          had_cmd, had_cmd_n;
  logic          limited, limited_n;
  logic          cnt_phase, cnt_phase_n;
  logic [CW-1:0] left, left_n;
  ev_kind_e      k;

  assign k     = ev_kind_e'(kind);
  assign waddr = wptr;
  assign raddr = wptr;
  assign wdata = ev_byte;

  always_comb begin
    st_n        = st;
    cmd_ptr_n   = cmd_ptr;
    wptr_n      = wptr;
    blk_sel_n   = blk_sel;
    had_cmd_n   = had_cmd;
    limited_n   = limited;
    cnt_phase_n = cnt_phase;
    left_n      = left;
    we          = 1'b0;
    need_rsp    = 1'b0;
    rsp_d.ack   = 1'b0;
    rsp_d.data  = 8'hFF;
    if (acc) begin
      unique case (k)
        EV_START: st_n = S_ADDR;
        EV_STOP: begin
          st_n      = S_IDLE;
          had_cmd_n = 1'b0;
        end
        EV_ADDR: begin
          need_rsp = 1'b1;
          if (st == S_ADDR && ev_byte[7:1] == TGT_ADDR) begin
            rsp_d.ack = 1'b1;
            if (!ev_byte[0]) begin
              st_n = S_CMD;
            end else begin
              st_n        = S_RD;
              wptr_n      = cmd_ptr;
              cnt_phase_n = had_cmd && blk_sel;
              limited_n   = had_cmd && blk_sel;
              left_n      = CW'(RD_BLK_LEN);
            end
          end else begin
            st_n = S_DROP;
          end
        end
        EV_WDATA: begin
          need_rsp = 1'b1;
          case (st)
            S_CMD: begin
              rsp_d.ack = 1'b1;
              cmd_ptr_n = ev_byte[AW-1:0];
              wptr_n    = ev_byte[AW-1:0];
              blk_sel_n = ev_byte[7];
              limited_n = ev_byte[7];
              had_cmd_n = 1'b1;
              st_n      = ev_byte[7] ? S_CNT : S_WDAT;
            end
            S_CNT: begin
              if (ev_byte != 8'd0 && int'(ev_byte) <= MAX_BLK) begin
                rsp_d.ack = 1'b1;
                left_n    = CW'(ev_byte);
                st_n      = S_WDAT;
              end else begin
                st_n = S_DROP;
              end
            end
            S_WDAT: begin
              if (limited && left == '0) begin
                st_n = S_DROP;
              end else begin
                we        = 1'b1;
                rsp_d.ack = 1'b1;
                wptr_n    = wptr + 1'b1;
                if (limited) left_n = left - 1'b1;
              end
            end
            default: ;
          endcase
        end
        EV_TXREQ: begin
          need_rsp = 1'b1;
          if (st == S_RD) begin
            if (cnt_phase) begin
              rsp_d.ack  = 1'b1;
              rsp_d.data = 8'(RD_BLK_LEN);
            end else if (!limited || left != '0) begin
              rsp_d.ack  = 1'b1;
              rsp_d.data = rdata;
            end
          end
        end
        EV_MACK: begin
          if (st == S_RD) begin
            if (!ev_byte[0]) begin
              st_n = S_RDONE;
            end else if (cnt_phase) begin
              cnt_phase_n = 1'b0;
            end else begin
              wptr_n = wptr + 1'b1;
              if (limited && left != '0) left_n = left - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_ptr   <= '0;
      wptr      <= '0;
      blk_sel   <= 1'b0;
      had_cmd   <= 1'b0;
      limited   <= 1'b0;
      cnt_phase <= 1'b0;
      left      <= '0;
    end else begin
      st        <= st_n;
      cmd_ptr   <= cmd_ptr_n;
      wptr      <= wptr_n;
      blk_sel   <= blk_sel_n;
      had_cmd   <= had_cmd_n;
      limited   <= limited_n;
      cnt_phase <= cnt_phase_n;
      left      <= left_n;
    end
  end

  assert_block_left_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left) <= MAX_BLK);

  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && k == EV_STOP) |=> st == S_IDLE);

  assert_master_nack_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && k == EV_MACK && !ev_byte[0] && st == S_RD) |=> st == S_RDONE);
endmodule

// File: rtl/smbus_rsp_stage.sv
module smbus_rsp_stage
  import smbus_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rsp_t       rsp_d,
  output logic       rsp_valid,
  output logic       rsp_ack,
  output logic [7:0] rsp_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_byte  <= 8'hFF;
    end else begin
      rsp_valid <= load;
      if (load) begin
        rsp_ack  <= rsp_d.ack;
        rsp_byte <= rsp_d.data;
      end
    end
  end
endmodule

// File: rtl/smbus_target_resp.sv
module smbus_target_resp
  import smbus_resp_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR   = 7'h3A,
  parameter int         AW         = 7,
  parameter int         MAX_BLK    = 32,
  parameter int         RD_BLK_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       rsp_valid,
  output logic       rsp_ack,
  output logic [7:0] rsp_byte
);
  logic          acc;
  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          need_rsp;
  rsp_t          rsp_d;

  assign ev_ready = !rsp_valid;
  assign acc      = ev_valid && ev_ready;

  smbus_regbank #(.AW(AW), .DW(8)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  smbus_proto #(
    .TGT_ADDR   (TGT_ADDR),
    .AW         (AW),
    .MAX_BLK    (MAX_BLK),
    .RD_BLK_LEN (RD_BLK_LEN)
  ) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .kind     (ev_kind),
    .ev_byte  (ev_byte),
    .rdata    (rdata),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (raddr),
    .need_rsp (need_rsp),
    .rsp_d    (rsp_d)
  );

  smbus_rsp_stage u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (need_rsp),
    .rsp_d     (rsp_d),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_byte  (rsp_byte)
  );

  assert_foreign_addr_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_kind_e'(ev_kind) == EV_ADDR && ev_byte[7:1] != TGT_ADDR)
      |=> (rsp_valid && !rsp_ack));

  assert_store_is_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rsp_valid && rsp_ack));

  assert_answer_next_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (ev_kind_e'(ev_kind) == EV_ADDR || ev_kind_e'(ev_kind) == EV_WDATA ||
             ev_kind_e'(ev_kind) == EV_TXREQ)) |=> rsp_valid);

  assert_single_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/test_smbus_target_resp.sv
`timescale 1ns/1ps
module test_smbus_target_resp;
  localparam logic [2:0] K_START = 3'd0;
  localparam logic [2:0] K_STOP  = 3'd1;
  localparam logic [2:0] K_ADDR  = 3'd2;
  localparam logic [2:0] K_WDATA = 3'd3;
  localparam logic [2:0] K_TXREQ = 3'd4;
  localparam logic [2:0] K_MACK  = 3'd5;
  localparam logic [7:0] A_WR    = {7'h3A, 1'b0};
  localparam logic [7:0] A_RD    = {7'h3A, 1'b1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       rsp_valid;
  logic       rsp_ack;
  logic [7:0] rsp_byte;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smbus_target_resp i_smbus_target_resp (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_byte(rsp_byte)
  );

  task automatic chk(input string req, input string what, input logic [8:0] got,
                     input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic ctl(input logic [2:0] k, input logic [7:0] b);
    drive(k, b);
    chk("R11", "no response to control event", {8'd0, rsp_valid}, 9'd0);
  endtask

  task automatic bus(input logic [2:0] k, input logic [7:0] b, input logic exp_ack,
                     input string req, input string what);
    drive(k, b);
    chk("R11", "response valid", {8'd0, rsp_valid}, 9'd1);
    chk("R11", "ready low during response", {8'd0, ev_ready}, 9'd0);
    chk(req, what, {8'd0, rsp_ack}, {8'd0, exp_ack});
  endtask

  task automatic rd(input logic exp_ack, input logic [7:0] exp_b, input string req,
                    input string what);
    drive(K_TXREQ, 8'h00);
    chk("R11", "response valid", {8'd0, rsp_valid}, 9'd1);
    chk(req, what, {rsp_ack, rsp_byte}, {exp_ack, exp_b});
  endtask

  task automatic set_cmd_read(input logic [7:0] cmd);
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own write address");
    bus(K_WDATA, cmd, 1'b1, "R2", "command byte");
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R4", "read after repeated start");
  endtask

  task automatic t_reset;
    chk("R12", "rsp_valid after reset", {8'd0, rsp_valid}, 9'd0);
    chk("R12", "ev_ready after reset", {8'd0, ev_ready}, 9'd1);
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R12", "bare read address");
    rd(1'b1, 8'h00, "R12", "register 0 after reset");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_byte_word;
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'h10, 1'b1, "R2", "command 0x10");
    bus(K_WDATA, 8'hA5, 1'b1, "R2", "byte write");
    ctl(K_STOP, 0);
    set_cmd_read(8'h10);
    rd(1'b1, 8'hA5, "R2", "byte read back");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'h20, 1'b1, "R2", "command 0x20");
    bus(K_WDATA, 8'h34, 1'b1, "R3", "word low");
    bus(K_WDATA, 8'h12, 1'b1, "R3", "word high");
    ctl(K_STOP, 0);
    set_cmd_read(8'h20);
    rd(1'b1, 8'h34, "R4", "word read low first");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'h12, "R4", "word read high second");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_wrap;
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'h7F, 1'b1, "R2", "command 0x7F");
    bus(K_WDATA, 8'h11, 1'b1, "R3", "byte at 0x7F");
    bus(K_WDATA, 8'h22, 1'b1, "R3", "byte wraps to 0x00");
    ctl(K_STOP, 0);
    set_cmd_read(8'h00);
    rd(1'b1, 8'h22, "R3", "wrapped byte at 0x00");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_receive_foreign;
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R5", "bare read address");
    rd(1'b1, 8'h22, "R5", "receive byte uses last command");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, {7'h3B, 1'b0}, 1'b0, "R1", "foreign address NACK");
    bus(K_WDATA, 8'h10, 1'b0, "R1", "byte after foreign address");
    bus(K_WDATA, 8'h99, 1'b0, "R1", "second byte after foreign address");
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R1", "bare read after foreign");
    rd(1'b1, 8'h22, "R1", "pointer untouched by foreign traffic");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
    set_cmd_read(8'h10);
    rd(1'b1, 8'hA5, "R1", "register untouched by foreign traffic");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_block_write;
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'hC0, 1'b1, "R6", "block command 0x40");
    bus(K_WDATA, 8'd3, 1'b1, "R6", "count 3");
    bus(K_WDATA, 8'hD1, 1'b1, "R6", "block byte 1");
    bus(K_WDATA, 8'hD2, 1'b1, "R6", "block byte 2");
    bus(K_WDATA, 8'hD3, 1'b1, "R6", "block byte 3");
    bus(K_WDATA, 8'hD4, 1'b0, "R6", "excess byte NACK");
    ctl(K_STOP, 0);
    set_cmd_read(8'h40);
    rd(1'b1, 8'hD1, "R6", "reg 0x40");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'hD2, "R6", "reg 0x41");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'hD3, "R6", "reg 0x42");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'h00, "R6", "excess byte discarded");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'hE0, 1'b1, "R6", "block command 0x60");
    bus(K_WDATA, 8'd32, 1'b1, "R6", "count 32 accepted");
    for (int i = 1; i <= 32; i++) bus(K_WDATA, 8'(i), 1'b1, "R6", "32-byte block");
    bus(K_WDATA, 8'hEE, 1'b0, "R6", "byte 33 NACK");
    ctl(K_STOP, 0);
    set_cmd_read(8'h7F);
    rd(1'b1, 8'h20, "R6", "last of 32-byte block");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'h22, "R6", "byte 33 not wrapped into 0x00");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_bad_count;
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'hD0, 1'b1, "R7", "block command 0x50");
    bus(K_WDATA, 8'd0, 1'b0, "R7", "count 0 NACK");
    bus(K_WDATA, 8'h77, 1'b0, "R7", "byte after count 0");
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'hD0, 1'b1, "R7", "block command 0x50");
    bus(K_WDATA, 8'd33, 1'b0, "R7", "count 33 NACK");
    bus(K_WDATA, 8'h66, 1'b0, "R7", "byte after count 33");
    ctl(K_STOP, 0);
    set_cmd_read(8'h50);
    rd(1'b1, 8'h00, "R7", "reg 0x50 unchanged");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  task automatic t_block_read;
    set_cmd_read(8'hC0);
    rd(1'b1, 8'd4, "R8", "count byte first");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'hD1, "R8", "block byte 1");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'hD2, "R8", "block byte 2");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'hD3, "R8", "block byte 3");
    ctl(K_MACK, 8'h01);
    rd(1'b1, 8'h00, "R8", "block byte 4");
    ctl(K_MACK, 8'h01);
    rd(1'b0, 8'hFF, "R8", "past block end");
    ctl(K_STOP, 0);
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R5", "bare read after block command");
    rd(1'b1, 8'hD1, "R5", "bare read sends no count");
    ctl(K_MACK, 8'h00);
    rd(1'b0, 8'hFF, "R9", "request after master NACK");
    ctl(K_STOP, 0);
  endtask

  task automatic t_stop_idle;
    ctl(K_START, 0);
    bus(K_ADDR, A_WR, 1'b1, "R1", "own address");
    bus(K_WDATA, 8'h10, 1'b1, "R2", "command 0x10");
    ctl(K_STOP, 0);
    bus(K_WDATA, 8'h55, 1'b0, "R10", "byte after stop NACK");
    rd(1'b0, 8'hFF, "R10", "request after stop");
    ctl(K_START, 0);
    bus(K_ADDR, A_RD, 1'b1, "R10", "bare read");
    rd(1'b1, 8'hA5, "R10", "pointer kept, write discarded");
    ctl(K_MACK, 8'h00);
    ctl(K_STOP, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_word();
    t_wrap();
    t_receive_foreign();
    t_block_write();
    t_bad_count();
    t_block_read();
    t_stop_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule